// File: doc/BRIEF.md
# Three-Wire Serial Clock-Chip Bus Master

This block is the bus master for a real-time-clock device on a three-wire serial link. The link has a chip-enable line, a serial clock, a data line that turns around between host and device, and a direction output that tells the board which way the data line points. A local controller gives the block one byte-level request at a time: open a transaction with a command byte, write a data byte, read a data byte, or close the transaction. The block shifts each byte least-significant bit first. It holds every setup and hold interval as a count of system clock cycles, and it returns read bytes on a valid/ready handshake.

Two parameters set the intervals. `T_CE` is the number of cycles held around chip-enable changes, and `T_CLK` is the number of cycles held around each serial-clock change. Both are rounded-up cycle counts of the device minimums. With a 50 MHz system clock they are 50 (1 µs) and 13 (250 ns). The defaults also meet the shorter data-setup and pre-sample minimums, because each data change and each sample is separated from the neighbouring clock edge by a full `T_CLK` interval. At the end of a command byte or a data byte, chip enable and serial clock stay high. The next falling clock edge then presents the device's first read bit.

Top module: `rtc3w_master`

## Requirements
- R1: After reset, `rtc_ce`, `rtc_sclk`, `rtc_dir` and `rtc_dq_o` are low, `rtc_dq_oe` is high, `req_ready` is high and `rsp_valid` is low.
- R2: An accepted open request (`req_op` = 2'b00) drives all four lines low for `T_CE` cycles. It then raises `rtc_ce` for `T_CE` cycles and shifts `req_data` out as a command byte using the write bit timing of R3. This holds whether the block was idle or already inside a transaction.
- R3: A write (`req_op` = 2'b01) sends each bit in two phases. First `rtc_sclk` keeps its level for `T_CLK` cycles. Then `rtc_sclk` is low for `T_CLK` cycles with `rtc_dq_o` showing the bit, and then `rtc_sclk` rises while `rtc_dq_o` holds. Bit 0 goes first. After bit 7, `rtc_ce` and `rtc_sclk` stay high and `rtc_dq_o` keeps bit 7.
- R4: A read (`req_op` = 2'b10) raises `rtc_dir` and drives `rtc_dq_o` low in the cycle after acceptance. `rtc_dq_oe` is low exactly while `rtc_dir` is high. Each bit is `T_CLK` cycles with `rtc_sclk` high followed by `T_CLK` cycles low. `rtc_dq_i` is sampled at the edge that raises `rtc_sclk`. The first sampled bit becomes bit 0 of `rsp_data`.
- R5: After the eighth read bit, `rsp_valid` is high with the byte on `rsp_data`. Both stay unchanged until `rsp_ready` is high at a clock edge, and `req_ready` is low for that whole time.
- R6: A close request (`req_op` = 2'b11) keeps all lines unchanged for `T_CLK` cycles. It then drives `rtc_ce`, `rtc_sclk`, `rtc_dir` and `rtc_dq_o` low together and returns to idle.
- R7: `req_ready` is high only while idle (all lines low) or while inside a transaction between bytes (`rtc_ce` and `rtc_sclk` high). While idle, write, read and close requests are accepted and have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 2 | 00 open with command, 01 write, 10 read, 11 close |
| req_data | input | 8 | Command byte or write data |
| rsp_valid | output | 1 | Read byte available |
| rsp_ready | input | 1 | Read byte consumed |
| rsp_data | output | 8 | Read byte |
| rtc_ce | output | 1 | Chip enable to the device |
| rtc_sclk | output | 1 | Serial clock to the device |
| rtc_dir | output | 1 | Direction control, high while the device drives data |
| rtc_dq_o | output | 1 | Data toward the device |
| rtc_dq_oe | output | 1 | Output enable for the data driver |
| rtc_dq_i | input | 1 | Data from the device |

## Verification
A wrong sequencer state or interval counter shows on the pins within one phase. It appears as a serial-clock or chip-enable edge that comes a cycle early or late, or as a data level on the wrong phase. The per-cycle comparison reports it in the first mismatching cycle. A bit-index or shift fault appears as a wrong data level on the eighth bit of a write, or as a wrong response byte as soon as `rsp_valid` rises. A fault in the handshake or turnaround appears at the same edge: `req_ready` at the wrong time, or the data enable on while the direction line is high.

// File: rtl/rtc3w_pkg.sv
package rtc3w_pkg;

  typedef enum logic [1:0] {
    OP_OPEN  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_CLOSE = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_QUIET,
    ST_CEUP,
    ST_PRE,
    ST_LOW,
    ST_RESP,
    ST_HOLD,
    ST_TAIL
  } st_e;

  typedef struct packed {
    logic ce;
    logic sclk;
    logic dir;
    logic dq;
  } lines_t;

endpackage

// File: rtl/rtc3w_timer.sv
module rtc3w_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/rtc3w_shifter.sv
module rtc3w_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift_en,
  input  logic         din,
  output logic         lsb,
  output logic         last,
  output logic [W-1:0] q
);

  localparam int IW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  sh_q, sh_d;
  logic [IW-1:0] idx_q, idx_d;

  always_comb begin
    sh_d  = sh_q;
    idx_d = idx_q;
    if (load) begin
      sh_d  = load_val;
      idx_d = '0;
    end else if (shift_en) begin
      sh_d  = {din, sh_q[W-1:1]};
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else begin
      sh_q  <= sh_d;
      idx_q <= idx_d;
    end
  end

  assign lsb  = sh_q[0];
  assign last = (idx_q == IW'(W - 1));
  assign q    = sh_q;

endmodule

// File: rtl/rtc3w_pins.sv
module rtc3w_pins
  import rtc3w_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   upd,
  input  lines_t nxt,
  output lines_t cur,
  output logic   oe
);

  lines_t ln_q;
  logic   oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ln_q <= '0;
      oe_q <= 1'b1;
    end else if (upd) begin
      ln_q <= nxt;
      oe_q <= ~nxt.dir;
    end
  end

  assign cur = ln_q;
  assign oe  = oe_q;

endmodule

// File: rtl/rtc3w_master.sv
module rtc3w_master
  import rtc3w_pkg::*;
#(
  parameter int T_CE   = 50,
  parameter int T_CLK  = 13,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [BYTE_W-1:0] req_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [BYTE_W-1:0] rsp_data,
  output logic              rtc_ce,
  output logic              rtc_sclk,
  output logic              rtc_dir,
  output logic              rtc_dq_o,
  output logic              rtc_dq_oe,
  input  logic              rtc_dq_i
);

  localparam int MAXD = (T_CE > T_CLK) ? T_CE : T_CLK;
  localparam int CW   = $clog2(MAXD + 1);
  localparam logic [CW-1:0] LD_CE  = CW'(T_CE - 1);
  localparam logic [CW-1:0] LD_CLK = CW'(T_CLK - 1);

  st_e    st_q, st_d;
  logic   rd_q, rd_d;
  lines_t cur, pin_n;
  logic   pin_upd;
  logic   t_load, t_zero;
  logic [CW-1:0] t_val;
  logic   sh_load, sh_en, sh_lsb, sh_last;
  logic [BYTE_W-1:0] sh_val, sh_q;
  logic   accept;
  op_e    op;

  assign op        = op_e'(req_op);
  assign req_ready = (st_q == ST_IDLE) || (st_q == ST_HOLD);
  assign accept    = req_valid && req_ready;

  // Next-state process
  always_comb begin
    st_d    = st_q;
    rd_d    = rd_q;
    pin_n   = cur;
    pin_upd = 1'b0;
    t_load  = 1'b0;
    t_val   = LD_CLK;
    sh_load = 1'b0;
    sh_val  = req_data;
    sh_en   = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_HOLD: begin
        if (accept) begin
          unique case (op)
            // R2: open drives every line low first
            OP_OPEN: begin
              pin_n   = '0;
              pin_upd = 1'b1;
              t_load  = 1'b1;
              t_val   = LD_CE;
              sh_load = 1'b1;
              rd_d    = 1'b0;
              st_d    = ST_QUIET;
            end
            // R3: write turns the line toward the device
            OP_WRITE: begin
              if (st_q == ST_HOLD) begin
                pin_n.dir = 1'b0;
                pin_upd   = 1'b1;
                t_load    = 1'b1;
                sh_load   = 1'b1;
                rd_d      = 1'b0;
                st_d      = ST_PRE;
              end
            end
            // R4: read releases data and raises direction
            OP_READ: begin
              if (st_q == ST_HOLD) begin
                pin_n.dir = 1'b1;
                pin_n.dq  = 1'b0;
                pin_upd   = 1'b1;
                t_load    = 1'b1;
                sh_load   = 1'b1;
                sh_val    = '0;
                rd_d      = 1'b1;
                st_d      = ST_PRE;
              end
            end
            // R6: close waits one clock interval
            OP_CLOSE: begin
              if (st_q == ST_HOLD) begin
                t_load = 1'b1;
                st_d   = ST_TAIL;
              end
            end
            default: ;
          endcase
        end
      end
      ST_QUIET: begin
        if (t_zero) begin
          pin_n.ce = 1'b1;
          pin_upd  = 1'b1;
          t_load   = 1'b1;
          t_val    = LD_CE;
          st_d     = ST_CEUP;
        end
      end
      ST_CEUP: begin
        if (t_zero) begin
          t_load = 1'b1;
          st_d   = ST_PRE;
        end
      end
      ST_PRE: begin
        if (t_zero) begin
          pin_n.sclk = 1'b0;
          if (!rd_q) pin_n.dq = sh_lsb;
          pin_upd = 1'b1;
          t_load  = 1'b1;
          st_d    = ST_LOW;
        end
      end
      ST_LOW: begin
        if (t_zero) begin
          pin_n.sclk = 1'b1;
          pin_upd    = 1'b1;
          sh_en      = 1'b1;
          if (sh_last) begin
            st_d = rd_q ? ST_RESP : ST_HOLD;
          end else begin
            t_load = 1'b1;
            st_d   = ST_PRE;
          end
        end
      end
      ST_RESP: begin
        if (rsp_ready) st_d = ST_HOLD;
      end
      ST_TAIL: begin
        if (t_zero) begin
          pin_n   = '0;
          pin_upd = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      rd_q <= 1'b0;
    end else begin
      st_q <= st_d;
      rd_q <= rd_d;
    end
  end

  rtc3w_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  rtc3w_shifter #(.W(BYTE_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sh_load),
    .load_val (sh_val),
    .shift_en (sh_en),
    .din      (rtc_dq_i),
    .lsb      (sh_lsb),
    .last     (sh_last),
    .q        (sh_q)
  );

  rtc3w_pins u_pins (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (pin_upd),
    .nxt   (pin_n),
    .cur   (cur),
    .oe    (rtc_dq_oe)
  );

  assign rtc_ce    = cur.ce;
  assign rtc_sclk  = cur.sclk;
  assign rtc_dir   = cur.dir;
  assign rtc_dq_o  = cur.dq;
  assign rsp_valid = (st_q == ST_RESP);
  assign rsp_data  = sh_q;

endmodule

// File: rtl/rtc3w_checker.sv
module rtc3w_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [BYTE_W-1:0] rsp_data,
  input logic              rtc_ce,
  input logic              rtc_sclk,
  input logic              rtc_dir,
  input logic              rtc_dq_o,
  input logic              rtc_dq_oe
);

  // R2
  ce_rise_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rtc_ce) |-> (!rtc_sclk && !rtc_dir));

  // R3
  sclk_rise_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rtc_sclk) |-> (rtc_ce && $stable(rtc_dq_o)));

  // R4
  dir_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_dir |-> !rtc_dq_oe);

  // R4
  dir_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rtc_dir |-> rtc_dq_oe);

  // R5
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R5
  rsp_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R6
  ce_fall_all_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rtc_ce) |-> (!rtc_sclk && !rtc_dir && !rtc_dq_o));

  // R7
  ready_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (rtc_ce == rtc_sclk));

endmodule

bind rtc3w_master rtc3w_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .rtc_ce    (rtc_ce),
  .rtc_sclk  (rtc_sclk),
  .rtc_dir   (rtc_dir),
  .rtc_dq_o  (rtc_dq_o),
  .rtc_dq_oe (rtc_dq_oe)
);

// File: tb/sim_rtc3w_master.sv
`timescale 1ns/100ps
module sim_rtc3w_master;

  localparam int TCE  = 50;
  localparam int TCLK = 13;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_op = 2'b00;
  logic [7:0] req_data = 8'h00;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_data;
  logic       rtc_ce, rtc_sclk, rtc_dir, rtc_dq_o, rtc_dq_oe;
  logic       rtc_dq_i = 1'b0;

  always #2.5 clk = ~clk;

  rtc3w_master #(.T_CE(TCE), .T_CLK(TCLK), .BYTE_W(8)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rtc_ce(rtc_ce), .rtc_sclk(rtc_sclk), .rtc_dir(rtc_dir),
    .rtc_dq_o(rtc_dq_o), .rtc_dq_oe(rtc_dq_oe), .rtc_dq_i(rtc_dq_i)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  string tag = "R1";
  bit    done = 1'b0;

  // device side: next bit after each falling serial clock while reading
  logic [7:0] dev_byte = 8'h00;
  int         dev_k = 0;
  always @(negedge rtc_sclk) begin
    if (rtc_dir) begin
      rtc_dq_i = dev_byte[dev_k % 8];
      dev_k++;
    end
  end

  // reference model: queue of expected {ce,sclk,dir,dq} per cycle
  logic [3:0] mq[$];
  logic [3:0] ml;
  logic [3:0] m_exp;
  bit         m_busy, m_rspv, m_rd, m_ready;
  logic [7:0] m_data;

  task automatic push(int n);
    for (int i = 0; i < n; i++) mq.push_back(ml);
  endtask

  task automatic shift_byte(logic [7:0] b, bit rd);
    for (int i = 0; i < 8; i++) begin
      push(TCLK);
      ml[2] = 1'b0;
      if (!rd) ml[0] = b[i];
      push(TCLK);
      ml[2] = 1'b1;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      mq.delete();
      ml = 4'b0000; m_exp = 4'b0000;
      m_busy = 0; m_rspv = 0; m_rd = 0; m_ready = 1;
    end else begin
      if (m_rspv) begin
        if (rsp_ready) m_rspv = 0;
      end else if (m_ready && req_valid) begin
        if (req_op == 2'b00) begin
          ml = 4'b0000; push(TCE);
          ml[3] = 1'b1; push(TCE);
          shift_byte(req_data, 1'b0);
          m_rd = 0;
        end else if (ml[3]) begin
          if (req_op == 2'b01) begin
            ml[1] = 1'b0; shift_byte(req_data, 1'b0); m_rd = 0;
          end else if (req_op == 2'b10) begin
            ml[1] = 1'b1; ml[0] = 1'b0; shift_byte(8'h00, 1'b1); m_rd = 1;
            m_data = dev_byte;
          end else begin
            push(TCLK); ml = 4'b0000; m_rd = 0;
          end
        end
        if (mq.size() > 0) begin m_exp = mq.pop_front(); m_busy = 1; end
      end else if (mq.size() > 0) begin
        m_exp = mq.pop_front();
      end else if (m_busy) begin
        m_busy = 0;
        m_exp  = ml;
        m_rspv = m_rd;
      end
      if (!m_busy) m_exp = ml;
      m_ready = !m_busy && !m_rspv;
    end
  end

  task automatic cmp1(string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", tag, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cyc > 2 && !done) begin
      cmp1("rtc_ce",    rtc_ce,    rst_n ? m_exp[3] : 1'b0);
      cmp1("rtc_sclk",  rtc_sclk,  rst_n ? m_exp[2] : 1'b0);
      cmp1("rtc_dir",   rtc_dir,   rst_n ? m_exp[1] : 1'b0);
      cmp1("rtc_dq_o",  rtc_dq_o,  rst_n ? m_exp[0] : 1'b0);
      cmp1("rtc_dq_oe", rtc_dq_oe, rst_n ? ~m_exp[1] : 1'b1);
      cmp1("req_ready", req_ready, rst_n ? m_ready : 1'b1);
      cmp1("rsp_valid", rsp_valid, rst_n ? m_rspv : 1'b0);
      if (rst_n && m_rspv) begin
        n_cmp++;
        if (rsp_data !== m_data) begin
          n_bad++;
          $display("FAIL %s rsp_data at cycle %0d: actual %h expected %h", tag, cyc, rsp_data, m_data);
        end
      end
    end
  end

  task automatic issue(logic [1:0] op, logic [7:0] d);
    @(negedge clk);
    req_op = op; req_data = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    do @(negedge clk); while (!req_ready);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    wait (cyc == 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog at cycle %0d: actual hung expected done", cyc);
    finish_run();
  end

  initial begin
    // R1 reset state
    tag = "R1";
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7 requests other than open while idle are ignored
    tag = "R7";
    issue(2'b01, 8'hFF);
    issue(2'b10, 8'h00);
    issue(2'b11, 8'h00);
    repeat (10) @(negedge clk);

    // R2 open with a write command byte
    tag = "R2";
    issue(2'b00, 8'h8C);
    settle();

    // R3 writes with distinct patterns
    tag = "R3";
    issue(2'b01, 8'hA5); settle();
    issue(2'b01, 8'h3C); settle();
    issue(2'b01, 8'h00); settle();
    issue(2'b01, 8'hFF); settle();

    // R6 close
    tag = "R6";
    issue(2'b11, 8'h00); settle();

    // R4 reads, back to back
    tag = "R2";
    issue(2'b00, 8'hC1); settle();
    tag = "R4";
    dev_byte = 8'h5A; dev_k = 0;
    issue(2'b10, 8'h00); settle();
    dev_byte = 8'h81; dev_k = 0;
    issue(2'b10, 8'h00); settle();

    // R5 response held while the consumer stalls
    tag = "R5";
    rsp_ready = 1'b0;
    dev_byte = 8'hB6; dev_k = 0;
    issue(2'b10, 8'h00);
    while (!rsp_valid) @(negedge clk);
    repeat (20) @(negedge clk);
    rsp_ready = 1'b1;
    settle();

    // R3 write straight after a read turns the line back
    tag = "R3";
    issue(2'b01, 8'h96); settle();

    // R2 open again while mid-transaction restarts
    tag = "R2";
    issue(2'b00, 8'h85); settle();
    tag = "R4";
    dev_byte = 8'h7E; dev_k = 0;
    issue(2'b10, 8'h00); settle();
    tag = "R6";
    issue(2'b11, 8'h00); settle();

    // R7 ignored again after closing
    tag = "R7";
    issue(2'b01, 8'h55);
    repeat (10) @(negedge clk);

    finish_run();
  end

endmodule